// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block captures serial words clocked in by an external master. The master drives a serial clock and a data line. The block brings both into its own clock domain through two-stage synchronizers, samples data on the selected edge of the serial clock and assembles an 8-bit or 9-bit word, least significant bit first. Each finished word goes into a two-entry holding queue. The oldest entry is shown on the read port, and a completion flag stays high while any entry is still unread.

Reception runs only when the port is enabled, synchronous mode is selected, the clock source is external (slave) and continuous receive is on. The single-receive control used by master mode is accepted but has no effect. If a word finishes while both queue entries are full, the word is dropped and an overrun is latched. Shifting then stops until continuous receive is turned off, which also clears the overrun. The interrupt output combines the completion flag with an enable. While the low-power input is high, reception carries on and the interrupt also drives a wake request.

Top module: `sync_slave_rx`

## Requirements
- R1: A word is received only while en_port=1, mode_sync=1, clk_master=0 and rx_cont=1. With any of these not met, serial clock edges leave the queue unchanged.
- R2: single_rx has no effect in this mode. With rx_cont=0 it does not start a reception, and with reception enabled it does not stop one.
- R3: Bits are taken least significant first. The active edge is rising when sclk_inv=0 and falling when sclk_inv=1. Each edge is acted on in the third clk rising edge after the line changes.
- R4: With nine_bit=1 a word is 9 bits long and its last bit appears on rd_ninth. With nine_bit=0 a word is 8 bits long and rd_ninth reads 0.
- R5: The queue holds two words in arrival order. rd_data shows the oldest entry, or 0 when the queue is empty. A one-cycle rd_pop removes that entry. rx_flag is 1 exactly while at least one entry is unread.
- R6: irq equals rx_flag AND irq_en.
- R7: wake equals irq AND sleep_mode. Reception continues while sleep_mode=1.
- R8: A word that completes while two entries are held is discarded and sets ovr_err. ovr_err holds, and no further word is taken, until rx_cont=0. ovr_err clears on the clk edge after rx_cont is seen low.
- R9: frm_err is always 0.
- R10: en_port=0 empties the queue on the next clk edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_in | input | 1 | Serial clock from the external master |
| sdata_in | input | 1 | Serial data line |
| en_port | input | 1 | Port enable; low flushes the queue |
| mode_sync | input | 1 | Synchronous mode select |
| clk_master | input | 1 | Clock source: 1 = internal master, 0 = external slave |
| nine_bit | input | 1 | 9-bit word select |
| rx_cont | input | 1 | Continuous receive enable; low clears the overrun |
| single_rx | input | 1 | Single-receive control, ignored in slave mode |
| sclk_inv | input | 1 | 0 = sample on rising edge, 1 = sample on falling edge |
| sleep_mode | input | 1 | System is in a low-power state |
| irq_en | input | 1 | Receive interrupt enable |
| rd_pop | input | 1 | Remove the oldest queue entry |
| rd_data | output | DATA_W | Low bits of the oldest entry |
| rd_ninth | output | 1 | Ninth bit of the oldest entry |
| rx_flag | output | 1 | At least one unread word |
| ovr_err | output | 1 | Overrun latched |
| frm_err | output | 1 | Framing error, constant 0 |
| irq | output | 1 | Receive interrupt request |
| wake | output | 1 | Wake request during low power |

## Verification
On every cycle the assertions check four things: the overrun is sticky while continuous receive is on and clears when it goes off, the completion flag only rises after a cycle in which all the enables were met, an unread word is never lost without a pop or a disable, and irq, wake and frm_err obey their gating. Several behaviours can only be shown by the bench's scenarios, because they depend on data. These are the bit order, the sampling edge for each polarity, the ninth-bit placement, the arrival order through the queue, and the word that is dropped on overrun. The bench's queue model is compared against all outputs on every clock.

// File: rtl/sync_slave_rx.sv
module sync_slave_rx #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              sdata_in,
  input  logic              en_port,
  input  logic              mode_sync,
  input  logic              clk_master,
  input  logic              nine_bit,
  input  logic              rx_cont,
  input  logic              single_rx,
  input  logic              sclk_inv,
  input  logic              sleep_mode,
  input  logic              irq_en,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ninth,
  output logic              rx_flag,
  output logic              ovr_err,
  output logic              frm_err,
  output logic              irq,
  output logic              wake
);
  localparam int WORD_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W  = $clog2(DEPTH + 1);

  logic [2:0]        ck_s;
  logic [1:0]        dt_s;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg, word_nx;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rptr, wptr;
  logic [OCC_W-1:0]  occ;
  logic              unused_ctl;

  assign unused_ctl = single_rx;

  wire active   = en_port & mode_sync & ~clk_master & rx_cont;
  wire act_edge = sclk_inv ? (~ck_s[1] & ck_s[2]) : (ck_s[1] & ~ck_s[2]);
  wire last_bit = bit_cnt == (nine_bit ? CNT_W'(WORD_W - 1) : CNT_W'(DATA_W - 1));
  wire take     = active & ~ovr_err & act_edge;
  wire done     = take & last_bit;
  wire full     = occ == OCC_W'(DEPTH);
  wire push     = done & ~full;
  wire pop      = rd_pop & (occ != '0);

  always_comb begin
    word_nx = shreg;
    word_nx[bit_cnt] = dt_s[1];
    if (!nine_bit) word_nx[WORD_W-1] = 1'b0;
  end

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_s    <= '0;
      dt_s    <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
      ovr_err <= 1'b0;
      rptr    <= '0;
      wptr    <= '0;
      occ     <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      ck_s <= {ck_s[1:0], sclk_in};
      dt_s <= {dt_s[0], sdata_in};

      if (!active || ovr_err) bit_cnt <= '0;
      else if (take) begin
        shreg   <= word_nx;
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
      end

      if (!rx_cont) ovr_err <= 1'b0;
      else if (done && full) ovr_err <= 1'b1;

      if (!en_port) begin
        rptr <= '0;
        wptr <= '0;
        occ  <= '0;
      end else begin
        if (push) begin
          mem[wptr] <= word_nx;
          wptr      <= step(wptr);
        end
        if (pop) rptr <= step(rptr);
        occ <= occ + OCC_W'(push) - OCC_W'(pop);
      end
    end
  end

  wire [WORD_W-1:0] head = mem[rptr];

  assign rx_flag  = occ != '0;
  assign rd_data  = rx_flag ? head[DATA_W-1:0] : '0;
  assign rd_ninth = rx_flag & head[DATA_W];
  assign irq      = rx_flag & irq_en;
  assign wake     = irq & sleep_mode;
  assign frm_err  = 1'b0;
endmodule

// File: rtl/sync_slave_rx_chk.sv
module sync_slave_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic en_port,
  input logic mode_sync,
  input logic clk_master,
  input logic rx_cont,
  input logic irq_en,
  input logic sleep_mode,
  input logic rd_pop,
  input logic rx_flag,
  input logic ovr_err,
  input logic frm_err,
  input logic irq,
  input logic wake
);
  assert_rise_needs_enables_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> $past(en_port && mode_sync && !clk_master && rx_cont));

  assert_word_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && !rd_pop && en_port) |=> rx_flag);

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

  assert_wake_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (irq && sleep_mode));

  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && rx_cont) |=> ovr_err);

  assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_cont |=> !ovr_err);

  assert_no_frame_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_err);

  assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_port |=> !rx_flag);
endmodule

bind sync_slave_rx sync_slave_rx_chk chk_i (.*);

// File: tb/sync_slave_rx_test.sv
module sync_slave_rx_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sclk_in, sdata_in, en_port, mode_sync, clk_master, nine_bit;
  logic rx_cont, single_rx, sclk_inv, sleep_mode, irq_en, rd_pop;
  logic [7:0] rd_data;
  logic rd_ninth, rx_flag, ovr_err, frm_err, irq, wake;

  sync_slave_rx uut (.*);

  int checks = 0, fails = 0, cyc = 0;
  bit cmp_en = 0, ended = 0;

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // behavioural reference model
  logic [8:0] mq[$];
  bit hs[$], hd[$];
  int m_cnt;
  bit m_ovr;
  logic [8:0] m_sh;

  always @(posedge clk) begin
    bit act, edg, pop_ok, full, fin;
    int nb;
    logic [8:0] w;
    if (!rst_n) begin
      mq.delete();
      hs = '{1'b0, 1'b0, 1'b0};
      hd = '{1'b0, 1'b0};
      m_cnt = 0; m_ovr = 0; m_sh = '0;
    end else begin
      act = en_port && mode_sync && !clk_master && rx_cont;
      edg = sclk_inv ? (hs[1] == 0 && hs[2] == 1) : (hs[1] == 1 && hs[2] == 0);
      nb = nine_bit ? 9 : 8;
      pop_ok = rd_pop && mq.size() > 0;
      full = mq.size() == 2;
      fin = 0;
      w = m_sh;
      w[m_cnt] = hd[1];
      if (!nine_bit) w[8] = 1'b0;
      if (!act || m_ovr) m_cnt = 0;
      else if (edg) begin
        m_sh = w;
        if (m_cnt == nb - 1) begin fin = 1; m_cnt = 0; end
        else m_cnt++;
      end
      if (!rx_cont) m_ovr = 0;
      else if (fin && full) m_ovr = 1;
      if (!en_port) mq.delete();
      else begin
        if (pop_ok) void'(mq.pop_front());
        if (fin && !full) mq.push_back(w);
      end
      hs.push_front(sclk_in); void'(hs.pop_back());
      hd.push_front(sdata_in); void'(hd.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en && !ended) begin
      chk("R5", "rd_data", rd_data, mq.size() > 0 ? int'(mq[0][7:0]) : 0);
      chk("R4", "rd_ninth", rd_ninth, mq.size() > 0 ? int'(mq[0][8]) : 0);
      chk("R5", "rx_flag", rx_flag, mq.size() > 0);
      chk("R6", "irq", irq, (mq.size() > 0) && irq_en);
      chk("R7", "wake", wake, (mq.size() > 0) && irq_en && sleep_mode);
      chk("R8", "ovr_err", ovr_err, m_ovr);
      chk("R9", "frm_err", frm_err, 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !ended) begin
      checks++; fails++;
      $display("FAIL watchdog expired got %0d expected below 100000", cyc);
      report();
    end
  end

  task automatic send(int val, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sdata_in = val[i];
      sclk_in = sclk_inv;
      repeat (4) @(negedge clk);
      sclk_in = ~sclk_inv;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pop_one();
    @(negedge clk); rd_pop = 1;
    @(negedge clk); rd_pop = 0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; sclk_in = 0; sdata_in = 0; en_port = 0; mode_sync = 0; clk_master = 0;
    nine_bit = 0; rx_cont = 0; single_rx = 0; sclk_inv = 0; sleep_mode = 0; irq_en = 0; rd_pop = 0;
    repeat (5) @(negedge clk);
    chk("R5", "reset rx_flag", rx_flag, 0);
    chk("R8", "reset ovr_err", ovr_err, 0);
    chk("R5", "reset rd_data", rd_data, 0);
    rst_n = 1;
    @(negedge clk); cmp_en = 1;

    en_port = 1; mode_sync = 1; single_rx = 1;
    send('h3C, 8);
    chk("R2", "single_rx without rx_cont", rx_flag, 0);
    rx_cont = 1; clk_master = 1;
    send('h3C, 8);
    chk("R1", "master clock source", rx_flag, 0);
    clk_master = 0; mode_sync = 0;
    send('h3C, 8);
    chk("R1", "async mode", rx_flag, 0);
    mode_sync = 1;
    send('hA5, 8);
    chk("R3", "lsb first rising", rd_data, 'hA5);
    chk("R2", "single_rx set while receiving", rx_flag, 1);
    pop_one();
    chk("R5", "empty after pop", rx_flag, 0);

    nine_bit = 1;
    send('h13C, 9);
    chk("R4", "ninth bit one", rd_ninth, 1);
    chk("R4", "data with ninth", rd_data, 'h3C);
    pop_one();
    send('h0C3, 9);
    chk("R4", "ninth bit zero", rd_ninth, 0);
    pop_one();
    nine_bit = 0;

    sclk_inv = 1;
    repeat (4) @(negedge clk);
    send('h5A, 8);
    chk("R3", "falling edge sample", rd_data, 'h5A);
    pop_one();
    sclk_inv = 0;
    repeat (4) @(negedge clk);

    send('h11, 8);
    send('h22, 8);
    chk("R5", "oldest shown first", rd_data, 'h11);
    send('h33, 8);
    chk("R8", "overrun on third word", ovr_err, 1);
    send('h44, 8);
    chk("R8", "stalled after overrun", rd_data, 'h11);
    rx_cont = 0;
    repeat (2) @(negedge clk);
    chk("R8", "overrun cleared", ovr_err, 0);
    pop_one();
    chk("R5", "second entry", rd_data, 'h22);
    pop_one();
    chk("R8", "dropped word absent", rx_flag, 0);
    rx_cont = 1;

    irq_en = 1; sleep_mode = 1;
    send('h77, 8);
    chk("R7", "wake in sleep", wake, 1);
    chk("R7", "data in sleep", rd_data, 'h77);
    chk("R6", "irq enabled", irq, 1);
    irq_en = 0;
    @(negedge clk);
    chk("R6", "irq masked", irq, 0);
    irq_en = 1; sleep_mode = 0;
    @(negedge clk);
    chk("R7", "no wake awake", wake, 0);

    en_port = 0;
    repeat (2) @(negedge clk);
    chk("R10", "flush on disable", rx_flag, 0);
    en_port = 1;
    repeat (4) @(negedge clk);
    report();
  end
endmodule